// File: doc/BRIEF.md
# Dual-Endian Load/Store Lane Aligner

This block sits between a 32-bit core and a 32-bit memory data bus. It places byte, word and longword accesses on the right byte lanes of the bus. A mode input picks big-endian or little-endian lane order. The mode can change from one access to the next.

For a store, the block takes the low two address bits, the access size and the register data. It returns four byte enables and a write word that carries the item on the enabled lanes.

For a load, it takes the raw bus word, picks out the addressed item and sign-extends it to 32 bits. Narrow loads are always sign-extended. An access whose address does not suit its size is flagged as misaligned and enables no lanes.

The parameter `REG_OUT` selects registered outputs (one clock of latency, the default) or a purely combinational path.

Top module: `lane_aligner`

## Requirements
- R1: With `big_end`=1 and `size`=0 (byte), address offset o enables only lane 3-o. Lane k is `byte_en[k]`, which covers bus bits 8k+7:8k, so offset 0 maps to bits 31:24.
- R2: With `big_end`=0 and `size`=0, address offset o enables only lane o, so offset 0 maps to bits 7:0.
- R3: With `size`=1 (word), offsets 0 and 2 are legal. In big-endian mode, offset 0 uses lanes 3:2 (bits 31:16) and offset 2 uses lanes 1:0. In little-endian mode the two are swapped.
- R4: With `size`=2 (longword) at offset 0, all four enables are set, `wr_data` equals `st_data` and `ld_data` equals `ld_bus`, in either mode.
- R5: A word at an odd offset, a longword at any nonzero offset, or the reserved size code 3 drives `misalign`=1, `byte_en`=0 and `ld_data`=0. Every other access drives `misalign`=0.
- R6: On every enabled lane, `wr_data` carries `st_data[7:0]` for a byte store and the matching byte of `st_data[15:0]` for a word store, with bit 15 on the upper enabled lane. Lanes that are not enabled are don't-care.
- R7: A byte load returns the addressed lane with bit 7 copied into bits 31:8. A word load returns the addressed half with bit 15 copied into bits 31:16.
- R8: With `REG_OUT`=1, the outputs reflect the inputs present at the previous rising clock edge, and an active-low `rst_n` clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset of the output register |
| big_end | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| size | input | 2 | 0 byte, 1 word, 2 longword, 3 reserved |
| addr_lo | input | 2 | Low address bits of the access |
| st_data | input | 32 | Register data to store, item right-aligned |
| ld_bus | input | 32 | Raw word read from the memory bus |
| byte_en | output | 4 | Store lane enables, bit k covers bits 8k+7:8k |
| wr_data | output | 32 | Store data placed on the lanes |
| ld_data | output | 32 | Extracted, sign-extended load result |
| misalign | output | 1 | Access address does not suit its size |

## Verification
The bench walks every combination of mode, size code and offset. This separates the lane choice in big-endian mode from the one in little-endian mode, and every legal offset from every misaligned one.

Load words mix lanes whose top bit is set with lanes whose top bit is clear. A missing or misplaced sign extension then shows up, and so does a pick of the wrong lane.

Store words carry a distinct value in each byte. A byte or word placed from the wrong part of `st_data`, or written in the wrong half order, is then caught.

A block of random accesses follows the exhaustive sweep, mixing the modes back to back.

// File: rtl/lane_aligner.sv
module lane_aligner #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_end,
  input  logic [1:0]  size,
  input  logic [1:0]  addr_lo,
  input  logic [31:0] st_data,
  input  logic [31:0] ld_bus,
  output logic [3:0]  byte_en,
  output logic [31:0] wr_data,
  output logic [31:0] ld_data,
  output logic        misalign
);
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_W = 2'd1;
  localparam logic [1:0] SZ_L = 2'd2;

  logic [1:0]  lane;
  logic        upper;
  logic        bad;
  logic [7:0]  b_pick;
  logic [15:0] h_pick;
  logic [3:0]  be_c;
  logic [31:0] wd_c, ld_c;

  assign lane   = addr_lo ^ {2{big_end}};
  assign upper  = addr_lo[1] ^ big_end;
  assign b_pick = ld_bus[{lane, 3'b000} +: 8];
  assign h_pick = upper ? ld_bus[31:16] : ld_bus[15:0];

  assign bad = (size == 2'd3) ||
               (size == SZ_W && addr_lo[0]) ||
               (size == SZ_L && addr_lo != 2'd0);

  always_comb begin
    be_c = 4'h0;
    wd_c = st_data;
    ld_c = ld_bus;
    case (size)
      SZ_B: begin
        be_c = 4'b0001 << lane;
        wd_c = {4{st_data[7:0]}};
        ld_c = {{24{b_pick[7]}}, b_pick};
      end
      SZ_W: begin
        be_c = upper ? 4'b1100 : 4'b0011;
        wd_c = {2{st_data[15:0]}};
        ld_c = {{16{h_pick[15]}}, h_pick};
      end
      default: be_c = 4'hF;
    endcase
    if (bad) begin
      be_c = 4'h0;
      ld_c = 32'h0;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byte_en  <= 4'h0;
          wr_data  <= 32'h0;
          ld_data  <= 32'h0;
          misalign <= 1'b0;
        end else begin
          byte_en  <= be_c;
          wr_data  <= wd_c;
          ld_data  <= ld_c;
          misalign <= bad;
        end
      end
    end else begin : g_comb
      assign byte_en  = be_c;
      assign wr_data  = wd_c;
      assign ld_data  = ld_c;
      assign misalign = bad;
    end
  endgenerate
endmodule

// File: rtl/lane_aligner_chk.sv
module lane_aligner_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  size,
  input logic [3:0]  byte_en,
  input logic [31:0] ld_data,
  input logic        misalign
);
  logic [1:0] p_size;
  logic       vld;

  generate
    if (REG_OUT) begin : g_p
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p_size <= 2'd0;
          vld    <= 1'b0;
        end else begin
          p_size <= size;
          vld    <= 1'b1;
        end
      end
    end else begin : g_d
      assign p_size = size;
      assign vld    = 1'b1;
    end
  endgenerate

  // R5
  no_lanes_on_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (byte_en == 4'h0 && ld_data == 32'h0));

  // R1
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && p_size == 2'd0 && !misalign) |-> $countones(byte_en) == 1);

  // R3
  word_half_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && p_size == 2'd1 && !misalign) |-> (byte_en == 4'b0011 || byte_en == 4'b1100));

  // R4
  long_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && p_size == 2'd2 && !misalign) |-> byte_en == 4'hF);

  // R5
  reserved_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && p_size == 2'd3) |-> misalign);

  // R7
  byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && p_size == 2'd0) |-> (ld_data[31:7] == 25'h0 || ld_data[31:7] == {25{1'b1}}));

  // R7
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && p_size == 2'd1) |-> (ld_data[31:15] == 17'h0 || ld_data[31:15] == {17{1'b1}}));
endmodule

bind lane_aligner lane_aligner_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .size(size),
  .byte_en(byte_en), .ld_data(ld_data), .misalign(misalign)
);

// File: tb/sim_lane_aligner.sv
`timescale 1ns/1ps
module sim_lane_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_end = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [1:0]  addr_lo = 2'd0;
  logic [31:0] st_data = 32'h0;
  logic [31:0] ld_bus = 32'h0;
  logic [3:0]  byte_en;
  logic [31:0] wr_data, ld_data;
  logic        misalign;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] ld;
    logic        mis;
    logic [1:0]  sz;
    logic        big;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  lane_aligner #(.REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .big_end(big_end), .size(size), .addr_lo(addr_lo),
    .st_data(st_data), .ld_bus(ld_bus), .byte_en(byte_en), .wr_data(wr_data),
    .ld_data(ld_data), .misalign(misalign)
  );

  function automatic exp_t model(logic big, logic [1:0] sz, logic [1:0] a,
                                 logic [31:0] sd, logic [31:0] bus);
    exp_t e;
    int pos;
    e = '0;
    e.sz = sz;
    e.big = big;
    e.mis = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a != 2'd0);
    if (e.mis) return e;
    case (sz)
      2'd0: begin
        pos = big ? 24 - 8 * int'(a) : 8 * int'(a);
        e.be[pos/8] = 1'b1;
        e.wd = {24'h0, sd[7:0]} << pos;
        e.ld = {{24{bus[pos+7]}}, bus[pos +: 8]};
      end
      2'd1: begin
        pos = big ? 16 - 8 * int'(a) : 8 * int'(a);
        e.be = (pos == 16) ? 4'b1100 : 4'b0011;
        e.wd = {16'h0, sd[15:0]} << pos;
        e.ld = {{16{bus[pos+15]}}, bus[pos +: 16]};
      end
      default: begin
        e.be = 4'hF;
        e.wd = sd;
        e.ld = bus;
      end
    endcase
    return e;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic big, logic [1:0] sz, logic [1:0] a,
                       logic [31:0] sd, logic [31:0] bus);
    @(negedge clk);
    big_end = big; size = sz; addr_lo = a; st_data = sd; ld_bus = bus;
    q.push_back(model(big, sz, a, sd, bus));
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      logic [31:0] m;
      string t;
      e = q.pop_front();
      m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
      if (e.mis) t = "R5";
      else if (e.sz == 2'd2) t = "R4";
      else if (e.sz == 2'd1) t = "R3";
      else t = e.big ? "R1" : "R2";
      chk({t, " misalign"}, {31'h0, misalign}, {31'h0, e.mis});
      chk({t, " byte_en"}, {28'h0, byte_en}, {28'h0, e.be});
      chk((e.sz == 2'd2) ? "R4 wr_data" : "R6 wr_data", wr_data & m, e.wd);
      chk(e.mis ? "R5 ld_data" : ((e.sz == 2'd2) ? "R4 ld_data" : "R7 ld_data"), ld_data, e.ld);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R8: reset clears every output
    chk("R8 reset byte_en", {28'h0, byte_en}, 32'h0);
    chk("R8 reset wr_data", wr_data, 32'h0);
    chk("R8 reset ld_data", ld_data, 32'h0);
    chk("R8 reset misalign", {31'h0, misalign}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 4; a++) begin
          drive(b[0], s[1:0], a[1:0], 32'h8A5C_13F7, 32'h80FF_7F01);
          drive(b[0], s[1:0], a[1:0], 32'h1234_F6E5, 32'h7F01_80FF);
        end
    for (int i = 0; i < 300; i++)
      drive(1'($urandom), 2'($urandom), 2'($urandom), $urandom, $urandom);
    // R8: latency of exactly one clock, then reset clears again
    @(negedge clk);
    big_end = 1'b1; size = 2'd2; addr_lo = 2'd0; st_data = 32'hCAFE_0001;
    @(posedge clk);
    #2;
    chk("R8 one-cycle latency", wr_data, 32'hCAFE_0001);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R8 async reset clears", wr_data, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule